// File: doc/BRIEF.md
# Clocked Serial Command Receiver

This block turns a single serial data line into command bytes for a downstream command interpreter. The line is sampled once per rising edge of the system clock, with no oversampling, so every bit occupies exactly one clock. A frame is a low start bit followed by eight data bits, least significant bit first. No stop bit is needed between frames, so a new start bit may follow the last data bit of the previous byte directly. Each completed byte appears on a held output together with a one-cycle valid strobe.

A long run of low samples is a break. It resynchronises the interface and is reported on its own one-cycle output as an interface reset. The zero run is counted across frame boundaries, so a break is caught even when its first zeros were taken for the start bit and data bits of an all-zero byte. After power-on reset the receiver stays silent until the line has been high for a set number of consecutive clocks. This clears any stale framing before the first start bit is trusted.

Top module: `cmd_rx`

## Requirements
- R1: While reset is asserted and right after it, the byte output is 0x00 and both the valid strobe and the break flag are low.
- R2: After reset the receiver ignores the line, emitting neither bytes nor breaks, until WAKE_LEN (default 10) consecutive high samples have been taken; any low sample restarts that count.
- R3: An armed receiver that samples the line high stays idle and emits nothing.
- R4: A low sample while idle is a start bit; the next eight samples form the byte, with the first sample after the start bit stored in bit 0 and the last in bit 7.
- R5: The valid strobe is high for exactly one clock, starting with the clock edge that samples the eighth data bit; the byte output keeps its value until the next byte completes.
- R6: A start bit sampled on the clock directly after the eighth data bit is accepted, so back-to-back frames with no stop bit are both received.
- R7: The break flag pulses high for exactly one clock, starting with the edge that samples the BREAK_LEN-th (default 10) consecutive low bit; the run counts start bits, data bits and idle samples alike.
- R8: When the sample that completes a break is also the eighth data bit of a frame, the break is reported and no byte is emitted.
- R9: After a break no further byte and no second break is produced while the line stays low; once a high sample is seen, the next start bit begins a normal frame.
- R10: An all-zero byte followed by a high sample (nine consecutive zeros) is received as 0x00 and is not a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sdi | input | 1 | Serial data line, one bit per clock, idle high |
| rx_byte | output | DATA_W | Last completed byte, held between strobes |
| rx_vld | output | 1 | One-clock strobe marking a new byte on rx_byte |
| rx_brk | output | 1 | One-clock strobe reporting a break (interface reset) |

## Verification
The deframer is driven with a set of single bytes chosen so that a swapped bit order, a dropped first bit or a stuck bit gives a different value (0xA5, 0x01, 0x80, 0xFF, 0x3C, 0x00 and others). Each byte is sent with idle high bits around it. Back-to-back frames with no stop bit check that the start-bit search resumes on the very next clock. Zero runs of nine, of ten placed inside a frame, and of well over ten separate the all-zero byte from a break, and show that a break which lands on the last data bit hides the byte. Short high runs after reset and unarmed zero runs show that arming needs an unbroken high stretch.

// File: rtl/cmd_rx_pkg.sv
`timescale 1ns/1ps
package cmd_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_HOLD = 2'd2
   } rx_state_e;
endpackage

// File: rtl/cmd_rx_wake.sv
`timescale 1ns/1ps
module cmd_rx_wake #(
   parameter int WAKE_LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sdi,
   output logic armed
);
   localparam int OW = $clog2(WAKE_LEN + 1);

   generate
      if (WAKE_LEN < 1) begin : g_bad_wake
         $error("cmd_rx_wake: WAKE_LEN must be at least 1");
      end
   endgenerate

   logic [OW-1:0] ones_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         armed  <= 1'b0;
      end else if (!armed) begin
         if (!sdi) begin
            ones_q <= '0;
         end else if (ones_q == OW'(WAKE_LEN - 1)) begin
            armed <= 1'b1;
         end else begin
            ones_q <= ones_q + 1'b1;
         end
      end
   end

   AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed); // R2
   AST_ARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(sdi)); // R2
endmodule

// File: rtl/cmd_rx_brkdet.sv
`timescale 1ns/1ps
module cmd_rx_brkdet #(
   parameter int BREAK_LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sdi,
   output logic hit
);
   localparam int ZW = $clog2(BREAK_LEN + 1);

   generate
      if (BREAK_LEN < 2) begin : g_bad_brk
         $error("cmd_rx_brkdet: BREAK_LEN must be at least 2");
      end
   endgenerate

   logic [ZW-1:0] zeros_q;

   // The sample in flight completes the run when it is low and the
   // count already holds one less than the break length.
   assign hit = en && !sdi && (zeros_q == ZW'(BREAK_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zeros_q <= '0;
      end else if (!en || sdi) begin
         zeros_q <= '0;
      end else if (zeros_q != ZW'(BREAK_LEN)) begin
         zeros_q <= zeros_q + 1'b1;
      end
   end

   AST_ZERO_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      zeros_q <= ZW'(BREAK_LEN)); // R7
   AST_HIT_ONCE_PER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit); // R9
endmodule

// File: rtl/cmd_rx_deframe.sv
`timescale 1ns/1ps
module cmd_rx_deframe
   import cmd_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              brk_hit,
   input  logic              sdi,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_vld,
   output logic              rx_brk
);
   localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   rx_state_e         st_q;
   logic [BW-1:0]     bit_q;
   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_nx;

   // Least significant bit arrives first, so each new sample enters at
   // the top and older samples move toward bit 0.
   assign shift_nx = {sdi, shift_q[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bit_q   <= '0;
         shift_q <= '0;
         rx_byte <= '0;
         rx_vld  <= 1'b0;
         rx_brk  <= 1'b0;
      end else begin
         rx_vld <= 1'b0;
         rx_brk <= 1'b0;
         if (!armed) begin
            st_q <= ST_IDLE;
         end else if (brk_hit) begin
            rx_brk <= 1'b1;
            st_q   <= ST_HOLD;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (!sdi) begin
                     st_q  <= ST_DATA;
                     bit_q <= '0;
                  end
               end
               ST_DATA: begin
                  shift_q <= shift_nx;
                  bit_q   <= bit_q + 1'b1;
                  if (bit_q == LAST_BIT) begin
                     rx_byte <= shift_nx;
                     rx_vld  <= 1'b1;
                     st_q    <= ST_IDLE;
                  end
               end
               ST_HOLD: begin
                  if (sdi) st_q <= ST_IDLE;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_VLD_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld |=> !rx_vld); // R5
   AST_BRK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_brk |=> !rx_brk); // R7
   AST_BRK_HIDES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_brk |-> !rx_vld); // R8
   AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD) |-> !rx_vld); // R9
   AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |-> $stable(rx_byte)); // R5
endmodule

// File: rtl/cmd_rx.sv
`timescale 1ns/1ps
module cmd_rx #(
   parameter int DATA_W    = 8,
   parameter int BREAK_LEN = 10,
   parameter int WAKE_LEN  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdi,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_vld,
   output logic              rx_brk
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cmd_rx: DATA_W must be at least 2");
      end
      if (BREAK_LEN < DATA_W + 2) begin : g_bad_break
         $error("cmd_rx: BREAK_LEN must exceed DATA_W + 1 so an all-zero byte is receivable");
      end
   endgenerate

   logic armed;
   logic brk_hit;

   cmd_rx_wake #(.WAKE_LEN(WAKE_LEN)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .sdi   (sdi),
      .armed (armed)
   );

   cmd_rx_brkdet #(.BREAK_LEN(BREAK_LEN)) u_brk (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (armed),
      .sdi   (sdi),
      .hit   (brk_hit)
   );

   cmd_rx_deframe #(.DATA_W(DATA_W)) u_dfr (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed),
      .brk_hit (brk_hit),
      .sdi     (sdi),
      .rx_byte (rx_byte),
      .rx_vld  (rx_vld),
      .rx_brk  (rx_brk)
   );

   AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!rx_vld && !rx_brk)); // R2
   AST_BRK_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rx_brk |-> !$past(sdi)); // R7
endmodule

// File: tb/cmd_rx_test.sv
`timescale 1ns/1ps
module cmd_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sdi = 1'b1;
   logic [7:0] rx_byte;
   logic       rx_vld;
   logic       rx_brk;

   int n_chk = 0;
   int n_bad = 0;
   int got_n = 0;
   int brk_n = 0;
   int wide_n = 0;
   logic [7:0] last_b = 8'h00;
   logic [7:0] prev_b = 8'h00;
   logic       vld_d = 1'b0;
   logic       brk_d = 1'b0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   cmd_rx uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sdi     (sdi),
      .rx_byte (rx_byte),
      .rx_vld  (rx_vld),
      .rx_brk  (rx_brk)
   );

   // Output monitor, sampled between rising edges.
   always @(negedge clk) begin
      if (rx_vld) begin
         got_n  = got_n + 1;
         prev_b = last_b;
         last_b = rx_byte;
         if (vld_d) wide_n = wide_n + 1;
      end
      if (rx_brk) begin
         brk_n = brk_n + 1;
         if (brk_d) wide_n = wide_n + 1;
      end
      vld_d = rx_vld;
      brk_d = rx_brk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      sdi = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b1);
   endtask

   task automatic send_frame(input logic [7:0] b);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
   endtask

   // {stimulus byte, expected byte}
   localparam logic [15:0] VEC [8] = '{
      16'hA5A5, 16'h0101, 16'h8080, 16'hFFFF,
      16'h0000, 16'h3C3C, 16'h1B1B, 16'hE6E6
   };

   initial begin
      int g0;
      int b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
      chk(!rx_vld && !rx_brk, "R1 strobes", {rx_vld, rx_brk}, 0);
      rst_n = 1'b1;

      // R2: short high run, a frame and a zero run while unarmed
      idle(5);
      send_frame(8'h5A);
      idle(3);
      for (int i = 0; i < 12; i++) send_bit(1'b0);
      idle(9);
      send_frame(8'h00);
      idle(2);
      chk(got_n == 0, "R2 no byte unarmed", got_n, 0);
      chk(brk_n == 0, "R2 no break unarmed", brk_n, 0);
      idle(12);

      // R3: idle line stays idle
      idle(20);
      chk(got_n == 0 && brk_n == 0, "R3 idle quiet", got_n + brk_n, 0);

      // R4 / R10: table of single frames
      b0 = brk_n;
      foreach (VEC[k]) begin
         send_frame(VEC[k][15:8]);
         idle(2);
         chk(got_n == k + 1, "R4 frame count", got_n, k + 1);
         chk(last_b == VEC[k][7:0], "R4 byte value", last_b, VEC[k][7:0]);
      end
      chk(brk_n == b0, "R10 nine zeros no break", brk_n, b0);

      // R5: strobe timing and hold
      send_frame(8'hC3);
      @(negedge clk);
      sdi = 1'b1;
      chk(rx_vld == 1'b1, "R5 strobe after last bit", rx_vld, 1);
      chk(rx_byte == 8'hC3, "R5 byte with strobe", rx_byte, 8'hC3);
      @(negedge clk);
      chk(rx_vld == 1'b0, "R5 strobe one clock", rx_vld, 0);
      idle(5);
      chk(rx_byte == 8'hC3, "R5 byte held", rx_byte, 8'hC3);

      // R6: back-to-back frames without stop bit
      g0 = got_n;
      send_frame(8'h12);
      send_frame(8'h34);
      idle(2);
      chk(got_n == g0 + 2, "R6 both frames", got_n, g0 + 2);
      chk(prev_b == 8'h12 && last_b == 8'h34, "R6 values", {prev_b, last_b}, 16'h1234);

      // R7 / R9: break built from an all-zero frame plus one more zero
      idle(3);
      g0 = got_n;
      b0 = brk_n;
      for (int i = 0; i < 10; i++) send_bit(1'b0);
      @(negedge clk);
      chk(rx_brk == 1'b1, "R7 break on tenth zero", rx_brk, 1);
      for (int i = 0; i < 15; i++) send_bit(1'b0);
      idle(2);
      chk(brk_n == b0 + 1, "R9 single break", brk_n, b0 + 1);
      chk(got_n == g0 + 1, "R9 no byte in hold", got_n, g0 + 1);
      send_frame(8'h6E);
      idle(2);
      chk(last_b == 8'h6E && got_n == g0 + 2, "R9 recovery frame", last_b, 8'h6E);

      // R8: break landing on the eighth data bit hides the byte
      idle(3);
      g0 = got_n;
      b0 = brk_n;
      send_frame(8'h7F);
      send_frame(8'h00);
      idle(3);
      chk(got_n == g0 + 1 && last_b == 8'h7F, "R8 byte hidden", got_n - g0, 1);
      chk(brk_n == b0 + 1, "R8 break reported", brk_n, b0 + 1);

      chk(wide_n == 0, "R5 strobe width", wide_n, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end
endmodule